// File: doc/BRIEF.md
# SDRAM Data-Side Beat Pipeline

This block handles the data side of a synchronous DRAM controller for a 16-bit device. A separate sequencer issues the commands; this block is told each READ, WRITE or burst STOP as it goes out. It counts the data beats of the burst, drives write data and the output enable in the beat cycles, and builds the byte-mask pins. Read data is sampled from the DQ input after the selected CAS latency and returned with a valid flag and the lane enables that applied to that beat.

The two directions treat the mask pins differently. For a write beat, the mask pins take the inverse of the user byte enables in the same cycle. For a read beat, the inverse of the byte enables must reach the pins two clock edges before the device drives that beat. A new command ends the burst in progress. A WRITE is accepted only after the data bus has had an idle clock since the last read beat. While the bus is not clear, the block drops the request and shows this on `wr_allow`.

A small state machine counts the beats. Its states are `ST_IDLE`, `ST_RD` and `ST_WR`. Its transitions are named `GO_RD`, `GO_WR`, `BEAT`, `LAST` and `HALT`:
- `GO_RD` and `GO_WR`: an accepted READ or WRITE whose burst is longer than one beat moves the machine to `ST_RD` or `ST_WR`. This happens from any state.
- `BEAT`: the machine stays in its burst state while beats remain, or at every cycle in full-page mode.
- `LAST`: the final beat of a counted burst returns the machine to `ST_IDLE`.
- `HALT`: a STOP, or a one-beat command, also returns the machine to `ST_IDLE`.

Top module: `sdram_dq_pipe`

## Requirements
- R1: A synchronous reset, held for at least four edges, leaves the block idle. `rd_valid`, `dq_oe` and `dqm` are 0 and `wr_allow` is 1. A reset in the middle of a read drops the beats still in flight.
- R2: `cas_lat3`=0 selects a latency of 2 and 1 selects 3. A read beat issued at edge E is sampled from `dq_in` at edge E+latency. It appears on `rd_data` with `rd_valid`=1 during the cycle that follows that edge.
- R3: `bl_code` 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. A 1 in bit 2 selects full page, which issues a beat every cycle until the next command. The beats run on consecutive edges, starting at the command edge.
- R4: An accepted WRITE drives `dq_oe`=1 and `dq_out`=`usr_wdata` in the command cycle. The same happens in each later beat cycle of the burst.
- R5: In a write beat, `dqm[k]` is the inverse of `usr_be[k]` in that same cycle. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R6: For a read beat issued at edge E, `usr_be` is sampled at E. Its inverse is on `dqm` at edge E+latency-2. `rd_lane` returns the same `usr_be` value with the captured data.
- R7: `wr_allow` at edge W is 0 if a read beat was issued at any edge from W-latency-1 to W-1. A WRITE offered while `wr_allow` is 0 is ignored entirely and drives nothing.
- R8: A READ that arrives during a read burst drops the old burst's unissued beats. The new beats start at the command edge.
- R9: `cmd_op` codes are 0 READ, 1 WRITE, 2 STOP and 3 reserved. A READ or STOP ends a write burst, so `dq_oe` falls in the command cycle. A STOP ends read issue. Code 3 has no effect.
- R10: Outside accepted write beats, `dq_oe` is 0 and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is issued at this edge |
| cmd_op | input | 2 | Command code: 0 read, 1 write, 2 stop, 3 reserved |
| cas_lat3 | input | 1 | 1 selects read latency 3, 0 selects 2 |
| bl_code | input | 3 | Burst length code |
| usr_wdata | input | DQ_W | Write data for the current beat |
| usr_be | input | DQ_W/8 | Byte enables for the current beat, read or write |
| dq_in | input | DQ_W | Sampled DQ bus |
| dq_out | output | DQ_W | DQ drive data |
| dq_oe | output | 1 | DQ output enable |
| dqm | output | DQ_W/8 | Byte-mask pins |
| wr_allow | output | 1 | A WRITE would be accepted at this edge |
| rd_data | output | DQ_W | Captured read beat |
| rd_valid | output | 1 | rd_data holds a new beat |
| rd_lane | output | DQ_W/8 | Byte enables that applied to the captured beat |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a write burst that a READ cuts short, and the mask for that read's first beat. At latency 2, both want the `dqm` pins in the command cycle. The bench places a READ two beats into a write burst and checks two things: `dq_oe` falls in that cycle, and the pins already carry the read mask. The second pair is a WRITE request and read beats still in flight. The bench sweeps the gap between a read and a write from one edge upward, for both latencies and for one-beat and two-beat reads. At each gap it works out from R7 whether the write is accepted, then checks `wr_allow`, `dq_oe` and the capture flags cycle by cycle.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;

    // Longest read latency supported by the capture pipeline
    localparam int MAX_CL = 3;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_STOP  = 2'd2,
        OP_NONE  = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } burst_st_e;

endpackage

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_dq_pkg::*;
#(
    parameter int MAX_BL_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_rd,
    input  logic       cmd_wr,
    input  logic       cmd_stop,
    input  logic [2:0] bl_code,
    output logic       rd_beat,
    output logic       wr_beat
);

    localparam int CNT_W = MAX_BL_LOG2;

    burst_st_e        st_q, st_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [CNT_W-1:0] first_left;
    logic             full_q, full_d;

    // Beats that remain after the command beat (R3)
    assign first_left = CNT_W'((1 << bl_code[1:0]) - 1);

    // Next-state logic: transitions GO_RD, GO_WR, BEAT, LAST, HALT
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        full_d = full_q;
        if (cmd_rd || cmd_wr) begin
            full_d = bl_code[2];
            left_d = first_left;
            if (bl_code[2] || (first_left != '0)) begin
                st_d = cmd_rd ? ST_RD : ST_WR;
            end else begin
                st_d = ST_IDLE;
            end
        end else if (cmd_stop) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_RD, ST_WR: begin
                    if (!full_q) begin
                        left_d = left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            st_d = ST_IDLE;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Output logic: which kind of beat runs at this edge
    always_comb begin
        rd_beat = cmd_rd;
        wr_beat = cmd_wr;
        if (!(cmd_rd || cmd_wr || cmd_stop)) begin
            unique case (st_q)
                ST_RD:   rd_beat = 1'b1;
                ST_WR:   wr_beat = 1'b1;
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            left_q <= '0;
            full_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
            full_q <= full_d;
        end
    end

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
    import sdram_dq_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int LANES = DQ_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cas_lat3,
    input  logic             rd_beat,
    input  logic [LANES-1:0] beat_be,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [DQ_W-1:0]  rd_data,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_lane,
    output logic [LANES-1:0] rd_dqm,
    output logic             rd_pend
);

    localparam int DEPTH = MAX_CL;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] v_q;
    logic [LANES-1:0] be_q [DEPTH];
    logic [LANES-1:0] mk_q;
    logic [IDX_W-1:0] tap;
    logic [IDX_W:0]   cl_val;

    assign cl_val = cas_lat3 ? (IDX_W+1)'(3) : (IDX_W+1)'(2);
    assign tap    = IDX_W'(cl_val - 1'b1);

    // Issue pipeline: stage k holds the beat issued k+1 edges ago
    always_ff @(posedge clk) begin
        if (rst) begin
            v_q[0]  <= 1'b0;
            be_q[0] <= '0;
        end else begin
            v_q[0]  <= rd_beat;
            be_q[0] <= beat_be;
        end
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[k]  <= 1'b0;
                be_q[k] <= '0;
            end else begin
                v_q[k]  <= v_q[k-1];
                be_q[k] <= be_q[k-1];
            end
        end
    end

    // Capture register: sample dq_in at the latency edge
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_lane  <= '0;
            mk_q     <= '0;
        end else begin
            rd_valid <= v_q[tap];
            if (v_q[tap]) begin
                rd_data <= dq_in;
                rd_lane <= be_q[tap];
            end
            mk_q <= rd_beat ? ~beat_be : '0;
        end
    end

    // Read mask reaches the pins two edges before its data beat
    assign rd_dqm = cas_lat3 ? mk_q : (rd_beat ? ~beat_be : '0);

    // Device may drive the bus now, later, or did on the previous edge
    always_comb begin
        rd_pend = rd_valid;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < int'(cl_val)) begin
                rd_pend = rd_pend | v_q[k];
            end
        end
    end

endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe
    import sdram_dq_pkg::*;
#(
    parameter int DQ_W        = 16,
    parameter int MAX_BL_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic                cas_lat3,
    input  logic [2:0]          bl_code,
    input  logic [DQ_W-1:0]     usr_wdata,
    input  logic [DQ_W/8-1:0]   usr_be,
    input  logic [DQ_W-1:0]     dq_in,
    output logic [DQ_W-1:0]     dq_out,
    output logic                dq_oe,
    output logic [DQ_W/8-1:0]   dqm,
    output logic                wr_allow,
    output logic [DQ_W-1:0]     rd_data,
    output logic                rd_valid,
    output logic [DQ_W/8-1:0]   rd_lane
);

    localparam int LANES = DQ_W / 8;

    logic             cmd_rd, cmd_wr, cmd_stop;
    logic             rd_beat, wr_beat, rd_pend;
    logic [LANES-1:0] rd_dqm;

    // Turnaround gate: WRITE only with the bus clear for an idle clock
    assign wr_allow = !rd_pend;
    assign cmd_rd   = cmd_valid && (cmd_op == OP_READ);
    assign cmd_wr   = cmd_valid && (cmd_op == OP_WRITE) && wr_allow;
    assign cmd_stop = cmd_valid && (cmd_op == OP_STOP);

    sdram_burst_seq #(
        .MAX_BL_LOG2(MAX_BL_LOG2)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cmd_rd  (cmd_rd),
        .cmd_wr  (cmd_wr),
        .cmd_stop(cmd_stop),
        .bl_code (bl_code),
        .rd_beat (rd_beat),
        .wr_beat (wr_beat)
    );

    sdram_rd_capture #(
        .DQ_W (DQ_W),
        .LANES(LANES)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cas_lat3(cas_lat3),
        .rd_beat (rd_beat),
        .beat_be (usr_be),
        .dq_in   (dq_in),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .rd_lane (rd_lane),
        .rd_dqm  (rd_dqm),
        .rd_pend (rd_pend)
    );

    // Pin side: write beats own the bus and the mask pins
    assign dq_oe  = wr_beat;
    assign dq_out = wr_beat ? usr_wdata : '0;
    assign dqm    = wr_beat ? ~usr_be : rd_dqm;

endmodule

// File: rtl/sdram_dq_pipe_chk.sv
module sdram_dq_pipe_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic            cas_lat3,
    input logic [DQ_W-1:0] usr_wdata,
    input logic [DQ_W-1:0] dq_out,
    input logic            dq_oe,
    input logic            wr_allow,
    input logic            rd_valid
);

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_valid);

    a_r2_latency_two: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && (cmd_op == 2'd0) && !cas_lat3, 3) |-> rd_valid);

    a_r2_latency_three: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && (cmd_op == 2'd0) && cas_lat3, 4) |-> rd_valid);

    a_r4_write_cmd_drives: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 2'd1) && wr_allow) |-> (dq_oe && (dq_out == usr_wdata)));

    a_r7_no_capture_in_write: assert property (@(posedge clk) disable iff (rst)
        dq_oe |=> !rd_valid);

    a_r9_read_ends_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ((cmd_op == 2'd0) || (cmd_op == 2'd2))) |-> !dq_oe);

endmodule

bind sdram_dq_pipe sdram_dq_pipe_chk #(.DQ_W(DQ_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cas_lat3 (cas_lat3),
    .usr_wdata(usr_wdata),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .wr_allow (wr_allow),
    .rd_valid (rd_valid)
);

// File: tb/sdram_dq_pipe_tb_top.sv
module sdram_dq_pipe_tb_top;

    localparam int DQ_W  = 16;
    localparam int LANES = DQ_W / 8;
    localparam int NE    = 8192;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd3;
    logic             cas_lat3 = 1'b0;
    logic [2:0]       bl_code = 3'd0;
    logic [DQ_W-1:0]  usr_wdata = '0;
    logic [LANES-1:0] usr_be = '0;
    logic [DQ_W-1:0]  dq_in = '0;
    logic [DQ_W-1:0]  dq_out, rd_data;
    logic             dq_oe, wr_allow, rd_valid;
    logic [LANES-1:0] dqm, rd_lane;

    always #2 clk = ~clk;

    sdram_dq_pipe #(.DQ_W(DQ_W)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cas_lat3(cas_lat3), .bl_code(bl_code), .usr_wdata(usr_wdata),
        .usr_be(usr_be), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .dqm(dqm), .wr_allow(wr_allow), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_lane(rd_lane)
    );

    bit         iss_rd [NE];
    bit         iss_wr [NE];
    logic [1:0] be_a   [NE];
    int         e = 0;
    int         cl = 2;
    int         checks = 0;
    int         errors = 0;
    bit         ended = 1'b0;
    string      tag = "R1";

    function automatic logic [15:0] f_dq(int k);
        logic [31:0] kk = k;
        return {kk[7:0] ^ 8'h5A, kk[7:0]};
    endfunction

    function automatic logic [15:0] g_wd(int k);
        logic [31:0] kk = k;
        return {~kk[7:0], kk[7:0] ^ 8'hC3};
    endfunction

    // R7: no read beat issued in the window [w-cl-1, w-1]
    function automatic bit model_allow(int w);
        for (int k = w - cl - 1; k < w; k++) begin
            if (k >= 0 && iss_rd[k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) edge %0d actual=%h expected=%h", req, tag, e, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic plan(bit v, logic [1:0] op, logic [2:0] bl);
        int len;
        if (!v || op == 2'd3) return;
        if (op == 2'd1 && !model_allow(e)) return;  // R7 rejected write
        for (int k = e; k < NE; k++) begin
            iss_rd[k] = 1'b0;
            iss_wr[k] = 1'b0;
        end
        if (op == 2'd2) return;
        len = bl[2] ? 256 : (1 << bl[1:0]);
        for (int i = 0; i < len; i++) begin
            if (e + i < NE) begin
                if (op == 2'd0) iss_rd[e+i] = 1'b1;
                else            iss_wr[e+i] = 1'b1;
            end
        end
    endtask

    task automatic cyc(bit v, logic [1:0] op, logic [2:0] bl, logic [1:0] be);
        bit         exp_allow, exp_v;
        logic [1:0] exp_dqm;
        logic [15:0] exp_out;
        int k;
        @(negedge clk);
        rst       = 1'b0;
        cmd_valid = v;
        cmd_op    = op;
        bl_code   = bl;
        usr_be    = be;
        usr_wdata = g_wd(e);
        dq_in     = f_dq(e);
        cas_lat3  = (cl == 3);
        be_a[e]   = be;
        exp_allow = model_allow(e);
        plan(v, op, bl);
        #1;
        check(wr_allow == exp_allow, "R7", 32'(wr_allow), 32'(exp_allow));
        check(dq_oe == iss_wr[e], iss_wr[e] ? "R4" : "R10", 32'(dq_oe), 32'(iss_wr[e]));
        exp_out = iss_wr[e] ? g_wd(e) : 16'h0;
        check(dq_out == exp_out, iss_wr[e] ? "R4" : "R10", 32'(dq_out), 32'(exp_out));
        if (iss_wr[e]) begin
            exp_dqm = ~be;
        end else begin
            k = e - (cl - 2);
            exp_dqm = (k >= 0 && iss_rd[k]) ? ~be_a[k] : 2'b00;
        end
        check(dqm == exp_dqm, iss_wr[e] ? "R5" : "R6", 32'(dqm), 32'(exp_dqm));
        k = e - 1 - cl;
        exp_v = (k >= 0) && iss_rd[k];
        check(rd_valid == exp_v, "R2", 32'(rd_valid), 32'(exp_v));
        if (exp_v) begin
            check(rd_data == f_dq(e - 1), "R2", 32'(rd_data), 32'(f_dq(e - 1)));
            check(rd_lane == be_a[k], "R6", 32'(rd_lane), 32'(be_a[k]));
        end
        @(posedge clk);
        e++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 3'd0, 2'(e));
    endtask

    // R1: reset of four edges, then idle outputs
    task automatic do_reset();
        for (int k = 0; k < NE; k++) begin
            iss_rd[k] = 1'b0;
            iss_wr[k] = 1'b0;
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rst = 1'b1;
            cmd_valid = 1'b0;
            @(posedge clk);
            e++;
        end
        @(negedge clk);
        #1;
        check(rd_valid == 1'b0, "R1", 32'(rd_valid), 32'd0);
        check(dq_oe == 1'b0, "R1", 32'(dq_oe), 32'd0);
        check(dqm == 2'b00, "R1", 32'(dqm), 32'd0);
        check(wr_allow == 1'b1, "R1", 32'(wr_allow), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired (%s)", tag);
        finish_run();
    end

    initial begin
        do_reset();
        for (int c = 2; c <= 3; c++) begin
            cl = c;
            idle(6);
            // R2 R3 R6: every counted read length, varying lane enables
            tag = "R2 R3 R6";
            for (int b = 0; b < 4; b++) begin
                cyc(1'b1, 2'd0, 3'(b), 2'b11);
                for (int i = 1; i < (1 << b); i++) cyc(1'b0, 2'd0, 3'd0, 2'(i));
                idle(8);
            end
            // R3 R9: full-page read continues until STOP
            tag = "R3 R9 full page read";
            cyc(1'b1, 2'd0, 3'd7, 2'b01);
            idle(11);
            cyc(1'b1, 2'd2, 3'd0, 2'b10);
            idle(8);
            // R4 R5 R10: every counted write length
            tag = "R4 R5 R10";
            for (int b = 0; b < 4; b++) begin
                cyc(1'b1, 2'd1, 3'(b), 2'b10);
                for (int i = 1; i < (1 << b); i++) cyc(1'b0, 2'd0, 3'd0, 2'(i + 1));
                idle(4);
            end
            tag = "R3 R4 full page write";
            cyc(1'b1, 2'd1, 3'd4, 2'b11);
            idle(9);
            cyc(1'b1, 2'd2, 3'd0, 2'b00);
            idle(4);
            // R7: sweep the read-to-write gap
            tag = "R7 turnaround sweep";
            for (int b = 0; b < 2; b++) begin
                for (int d = 1; d <= cl + 3; d++) begin
                    cyc(1'b1, 2'd0, 3'(b), 2'(d));
                    idle(d - 1);
                    cyc(1'b1, 2'd1, 3'd1, 2'b11);
                    idle(10);
                end
            end
            // R8: read interrupts read
            tag = "R8 read over read";
            cyc(1'b1, 2'd0, 3'd3, 2'b11);
            idle(2);
            cyc(1'b1, 2'd0, 3'd2, 2'b01);
            idle(12);
            cyc(1'b1, 2'd0, 3'd2, 2'b10);
            cyc(1'b1, 2'd0, 3'd1, 2'b11);
            idle(10);
            // R9: read and STOP end a write, reserved code ignored
            tag = "R9 write cut by read";
            cyc(1'b1, 2'd1, 3'd3, 2'b11);
            idle(2);
            cyc(1'b1, 2'd0, 3'd1, 2'b01);
            idle(10);
            tag = "R9 reserved code";
            cyc(1'b1, 2'd1, 3'd3, 2'b01);
            idle(2);
            cyc(1'b1, 2'd3, 3'd0, 2'b10);
            idle(3);
            cyc(1'b1, 2'd2, 3'd0, 2'b11);
            idle(4);
            tag = "R9 stop ends read";
            cyc(1'b1, 2'd0, 3'd3, 2'b11);
            cyc(1'b0, 2'd0, 3'd0, 2'b10);
            cyc(1'b1, 2'd2, 3'd0, 2'b01);
            idle(10);
            // R1: reset while read beats are in flight
            tag = "R1 mid-run reset";
            cyc(1'b1, 2'd0, 3'd2, 2'b11);
            cyc(1'b0, 2'd0, 3'd0, 2'b11);
            do_reset();
            idle(8);
        end
        finish_run();
    end

endmodule